// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on one output line. A host hands it a byte, and optionally a ninth bit, through a single-cycle write strobe. The byte waits in a one-deep holding register. A shift engine takes the byte over as soon as it is free, so the host can queue the next byte while the current frame is still on the line. The block has its own bit-rate divider. An 8-bit reload value and an oversampling select set the bit rate.

The line is meant to drive a tri-state pad. While the block is disabled, the output-enable is low. Two status signals go back to the host. The holding-empty flag, with a maskable interrupt, says a new byte may be written. The shifter-empty bit says no frame is loaded or in flight. Clearing the enable aborts the frame in progress. It does not discard a byte that is waiting in the holding register.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While enabled, the line idles high. A frame is one low start bit, then the data bits with bit 0 first, then one high stop bit.
- R2: With `frame9_sel` high at transfer time, a ninth data bit taken from `bit9_in` is sent after data bit 7 and before the stop bit.
- R3: One bit lasts (`baud_div`+1)×16 clock cycles when `os_fast_sel` is 1, and (`baud_div`+1)×64 cycles when it is 0.
- R4: A write when the holding register is empty and the shifter is idle is accepted on that clock edge and moves into the shifter on the next edge. `hold_empty` is low for exactly the cycle between those two edges, and `shift_empty` falls after the second edge. The start bit begins at the next bit tick.
- R5: A byte written while a frame is shifting is moved into the shifter at the final tick of that frame's stop bit. Its start bit follows with no idle gap.
- R6: `hold_empty` is high exactly when the block is enabled and the holding register is empty. It becomes high when the enable is set, and it falls only after a write.
- R7: `irq` equals `hold_empty` gated by `irq_en`.
- R8: `shift_empty` is high when no frame is loaded or being sent. After reset it is high.
- R9: The ninth bit and the 9-bit select are sampled at the edge where the byte enters the shifter. A change made after the write but before that transfer is what gets sent.
- R10: When `tx_en` goes low, `tx_oe` drops in the same cycle and the shifter returns to empty on the next edge. A byte held in the holding register is kept and is sent after re-enable.
- R11: A write while the holding register is already full replaces the waiting byte.
- R12: While disabled, the divider is held cleared. When `tx_en` is set with data already held, the start bit appears on the (P+1)-th falling clock edge after the enable, where P is one bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmitter enable; low aborts and releases the pin |
| frame9_sel | input | 1 | 1 selects 9 data bits per frame |
| bit9_in | input | 1 | Ninth data bit, sampled at transfer |
| baud_div | input | 8 | Divider reload value |
| os_fast_sel | input | 1 | 1: bit = 16 base ticks, 0: 64 base ticks |
| irq_en | input | 1 | Interrupt mask for the holding-empty flag |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_byte | input | 8 | Byte to write |
| tx_out | output | 1 | Serial data line |
| tx_oe | output | 1 | Output enable for the pad |
| hold_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Masked holding-empty interrupt |
| shift_empty | output | 1 | Shifter holds no frame |

## Verification
`tx_oe` follows the enable in the same cycle. `hold_empty` falls one edge after a write. The holding-to-shifter transfer and the fall of `shift_empty` come one edge later still. The line itself moves only on the edge after a bit tick, and the first tick comes P cycles after the divider starts counting. A behavioural model in the bench advances on every rising edge by the same rules. All outputs are compared with it on every falling edge, so each result is checked in the exact cycle it is due. Directed checks count falling edges to measure start-bit widths, the gap between back-to-back frames, the 9-bit frame layout and the delay from enable to the first start bit.

// File: rtl/uart_txd_pkg.sv
`timescale 1ns/1ps
package uart_txd_pkg;
  localparam int OS_FAST = 16;
  localparam int OS_SLOW = 64;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_ARMED,
    SH_START,
    SH_DATA,
    SH_STOP
  } sh_state_e;
endpackage

// File: rtl/uart_txd_baud.sv
`timescale 1ns/1ps
module uart_txd_baud #(
  parameter int DIV_W   = 8,
  parameter int OS_FAST = uart_txd_pkg::OS_FAST,
  parameter int OS_SLOW = uart_txd_pkg::OS_SLOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             fast_sel,
  output logic             bit_tick
);
  localparam int OS_W = $clog2(OS_SLOW);

  logic [DIV_W-1:0] base_q, base_d;
  logic [OS_W-1:0]  os_q, os_d;
  logic [OS_W-1:0]  os_last;
  logic             base_wrap, os_wrap;

  always_comb begin
    os_last   = fast_sel ? OS_W'(OS_FAST - 1) : OS_W'(OS_SLOW - 1);
    base_wrap = (base_q >= div);
    os_wrap   = (os_q >= os_last);
    bit_tick  = run & base_wrap & os_wrap;
  end

  always_comb begin
    base_d = base_q;
    os_d   = os_q;
    if (!run) begin
      base_d = '0;
      os_d   = '0;
    end else if (base_wrap) begin
      base_d = '0;
      os_d   = os_wrap ? '0 : os_q + 1'b1;
    end else begin
      base_d = base_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      os_q   <= '0;
    end else begin
      base_q <= base_d;
      os_q   <= os_d;
    end
  end

  // R3: a bit lasts at least 16 cycles, so ticks never come on adjacent cycles
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/uart_txd_hold.sv
`timescale 1ns/1ps
module uart_txd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_d;
  logic [W-1:0] data_d;

  always_comb begin
    full_d = full;
    data_d = data;
    if (wr) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end

  // R6: the register only becomes occupied through a host write
  a_r6_fill_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr));
endmodule

// File: rtl/uart_txd_shift.sv
`timescale 1ns/1ps
module uart_txd_shift
  import uart_txd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         bit_tick,
  input  logic         nine_mode,
  input  logic         ninth_in,
  input  logic         hold_full,
  input  logic [W-1:0] hold_data,
  output logic         take,
  output logic         line,
  output logic         idle
);
  localparam int CNT_W = $clog2(W + 1);

  sh_state_e        state_q, state_d;
  logic [W:0]       sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             nine_q, nine_d;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx = nine_q ? CNT_W'(W) : CNT_W'(W - 1);
    take = run & hold_full &
           ((state_q == SH_IDLE) | ((state_q == SH_STOP) & bit_tick));
  end

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    nine_d  = nine_q;
    if (!run) begin
      state_d = SH_IDLE;
    end else begin
      unique case (state_q)
        SH_IDLE:  if (take) state_d = SH_ARMED;
        SH_ARMED: if (bit_tick) state_d = SH_START;
        SH_START: if (bit_tick) begin
          state_d = SH_DATA;
          cnt_d   = '0;
        end
        SH_DATA:  if (bit_tick) begin
          sh_d = {1'b1, sh_q[W:1]};
          if (cnt_q == last_idx) state_d = SH_STOP;
          else cnt_d = cnt_q + 1'b1;
        end
        SH_STOP:  if (bit_tick) state_d = take ? SH_START : SH_IDLE;
        default:  state_d = SH_IDLE;
      endcase
      if (take) begin
        sh_d   = {ninth_in, hold_data};
        nine_d = nine_mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      nine_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      nine_q  <= nine_d;
    end
  end

  always_comb begin
    unique case (state_q)
      SH_START: line = 1'b0;
      SH_DATA:  line = sh_q[0];
      default:  line = 1'b1;
    endcase
    idle = (state_q == SH_IDLE);
  end

  // R10: dropping the enable empties the shifter by the next edge
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> idle);
  // R8: the shifter only leaves empty when a byte was waiting
  a_r8_load_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(hold_full));
  // R1: the line level only moves on the edge after a bit tick
  a_r1_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(line)) |-> $past(bit_tick));
endmodule

// File: rtl/uart_tx_dbuf.sv
`timescale 1ns/1ps
module uart_tx_dbuf #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              frame9_sel,
  input  logic              bit9_in,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              os_fast_sel,
  input  logic              irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              hold_empty,
  output logic              irq,
  output logic              shift_empty
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              bit_tick, take, hold_full, line;
  logic [DATA_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  uart_txd_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_core_n), .run(tx_en), .div(baud_div),
    .fast_sel(os_fast_sel), .bit_tick(bit_tick)
  );

  uart_txd_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_core_n), .wr(wr_valid), .wr_data(wr_byte),
    .take(take), .full(hold_full), .data(hold_data)
  );

  uart_txd_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .run(tx_en), .bit_tick(bit_tick),
    .nine_mode(frame9_sel), .ninth_in(bit9_in), .hold_full(hold_full),
    .hold_data(hold_data), .take(take), .line(line), .idle(shift_empty)
  );

  always_comb begin
    tx_oe      = tx_en;
    tx_out     = tx_en ? line : 1'b1;
    hold_empty = tx_en & ~hold_full;
    irq        = hold_empty & irq_en;
  end
endmodule

// File: tb/uart_tx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, nine = 1'b0, ninth = 1'b0, fast = 1'b1, ie = 1'b0, wr = 1'b0;
  logic [7:0] div = 8'd0, wdata = 8'd0;
  logic tx_out, tx_oe, hold_empty, irq, shift_empty;

  int errors = 0, checks = 0, cyc = 0;
  bit model_on = 1'b0, done = 1'b0;
  string scen = "R1";

  always #2.5 clk = ~clk;

  uart_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(en), .frame9_sel(nine), .bit9_in(ninth),
    .baud_div(div), .os_fast_sel(fast), .irq_en(ie), .wr_valid(wr), .wr_byte(wdata),
    .tx_out(tx_out), .tx_oe(tx_oe), .hold_empty(hold_empty), .irq(irq),
    .shift_empty(shift_empty)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int   m_cnt = 0;
  bit   m_full = 1'b0;
  logic [7:0] m_data = 8'd0;
  int   m_phase = 0;  // 0 empty, 1 loaded and waiting, 2 on the line
  int   q[$];

  task automatic m_build();
    q.delete();
    q.push_back(0);
    for (int i = 0; i < 8; i++) q.push_back(int'(m_data[i]));
    if (nine) q.push_back(int'(ninth));
    q.push_back(1);
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      int  per;
      bit  tick, took;
      per  = (int'(div) + 1) * (fast ? 16 : 64);
      tick = en && (m_cnt == per - 1);
      took = 1'b0;
      if (!en) begin
        m_cnt = 0; m_phase = 0; q.delete();
      end else begin
        m_cnt = tick ? 0 : m_cnt + 1;
        case (m_phase)
          0: if (m_full) begin m_build(); m_phase = 1; took = 1'b1; end
          1: if (tick) m_phase = 2;
          default: if (tick) begin
            void'(q.pop_front());
            if (q.size() == 0) begin
              if (m_full) begin m_build(); took = 1'b1; end
              else m_phase = 0;
            end
          end
        endcase
      end
      if (wr) begin m_full = 1'b1; m_data = wdata; end
      else if (took) m_full = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      int exp_line, exp_empty;
      exp_line  = (m_phase == 2) ? q[0] : 1;
      exp_empty = int'(en && !m_full);
      chk(int'(tx_oe), int'(en), {"R10 oe in ", scen});
      if (en) chk(int'(tx_out), exp_line, {"R1 line in ", scen});
      chk(int'(hold_empty), exp_empty, {"R6 empty in ", scen});
      chk(int'(irq), int'(exp_empty != 0 && ie), {"R7 irq in ", scen});
      chk(int'(shift_empty), int'(m_phase == 0), {"R8 shift_empty in ", scen});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic write(input logic [7:0] v);
    wr = 1'b1; wdata = v; step(1); wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(shift_empty && !hold_empty === 1'b0 ? shift_empty : shift_empty));
    step(2);
  endtask

  task automatic wait_low();
    do @(negedge clk); while (tx_out !== 1'b0);
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (tx_out === v) begin n++; @(negedge clk); end
  endtask

  task automatic reconfig(input logic [7:0] d, input logic f);
    en = 1'b0; step(1); div = d; fast = f; en = 1'b1; step(1);
  endtask

  initial begin
    int a, b, c;
    step(4); rst_n = 1'b1; step(4);
    @(negedge clk);
    chk(int'(tx_oe), 0, "R10 reset oe");
    chk(int'(hold_empty), 0, "R6 reset empty");
    chk(int'(irq), 0, "R7 reset irq");
    chk(int'(shift_empty), 1, "R8 reset shift_empty");
    step(1); model_on = 1'b1;

    // R1/R4/R6: first frame on an idle shifter
    scen = "R4"; ie = 1'b1; en = 1'b1; step(2);
    @(negedge clk); chk(int'(hold_empty), 1, "R6 set on enable");
    chk(int'(irq), 1, "R7 irq unmasked");
    step(1); write(8'hA5);
    @(negedge clk); chk(int'(hold_empty), 0, "R4 empty low after write");
    chk(int'(shift_empty), 1, "R4 shifter not yet loaded");
    step(1);
    @(negedge clk); chk(int'(hold_empty), 1, "R4 empty back after transfer");
    chk(int'(shift_empty), 0, "R4 shifter loaded");
    wait_idle();

    scen = "R7"; ie = 1'b0; step(2);
    @(negedge clk); chk(int'(irq), 0, "R7 masked irq"); chk(int'(hold_empty), 1, "R7 flag still set");
    step(1);

    // R3: bit width for three settings
    scen = "R3";
    reconfig(8'd0, 1'b1); write(8'hFF); wait_low(); run_len(1'b0, a);
    chk(a, 16, "R3 start width div0 x16"); wait_idle();
    reconfig(8'd2, 1'b1); write(8'hFF); wait_low(); run_len(1'b0, a);
    chk(a, 48, "R3 start width div2 x16"); wait_idle();
    reconfig(8'd1, 1'b0); write(8'hFF); wait_low(); run_len(1'b0, a);
    chk(a, 128, "R3 start width div1 x64"); wait_idle();

    // R12/R10: data held while disabled, then enable
    scen = "R12";
    en = 1'b0; step(1); div = 8'd0; fast = 1'b1; write(8'h3C);
    @(negedge clk); chk(int'(tx_oe), 0, "R10 oe low while disabled");
    chk(int'(hold_empty), 0, "R6 flag low while disabled");
    step(1); en = 1'b1; a = 0;
    do begin @(negedge clk); a++; end while (tx_out !== 1'b0);
    chk(a, 17, "R12 enable to start bit");
    scen = "R10"; write(8'h5A); step(40); en = 1'b0;
    @(negedge clk); chk(int'(tx_oe), 0, "R10 oe drops at once");
    step(1); @(negedge clk); chk(int'(shift_empty), 1, "R10 shifter cleared");
    step(3); en = 1'b1; step(1);
    @(negedge clk); chk(int'(shift_empty), 0, "R10 held byte reloaded");
    wait_idle();

    // R2: nine-bit frame with ninth bit 0
    scen = "R2"; nine = 1'b1; ninth = 1'b0; write(8'hFF);
    wait_low(); run_len(1'b0, a); run_len(1'b1, b); run_len(1'b0, c);
    chk(a, 16, "R2 start width"); chk(b, 128, "R2 eight ones"); chk(c, 16, "R2 ninth bit low");
    wait_idle();

    // R9: ninth bit changed after write, before transfer
    scen = "R9"; ninth = 1'b1; write(8'h81); step(3); write(8'h7E); ninth = 1'b0; step(2);
    wait_idle(); nine = 1'b0;

    // R5: back-to-back frames with no gap
    scen = "R5"; write(8'hFF); step(3); write(8'hFF);
    wait_low(); run_len(1'b0, a); run_len(1'b1, b); run_len(1'b0, c);
    chk(a, 16, "R5 first start"); chk(b, 144, "R5 data plus stop then no gap"); chk(c, 16, "R5 second start");
    wait_idle();

    // R11: second write replaces the waiting byte
    scen = "R11"; write(8'h0F); step(3); write(8'h11); write(8'h22);
    @(negedge clk); chk(int'(hold_empty), 0, "R11 holding still full");
    wait_idle(); step(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule